// File: doc/BRIEF.md
# Pin Security Attribute Change Monitor

This block keeps, for each of several pin groups, a 32-bit security attribute vector with one bit per pin, and a 32-bit watch register of the same width. Each watch bit does two jobs. It arms its pin, and it states the value the attribute bit is expected to hold. A 0 expects the attribute to stay low, so a rise is reported. A 1 expects it to stay high, so a fall is reported.

When an armed pin's attribute makes the reported change, the group's sticky flag is raised and driven on its interrupt output. Software clears the flag by writing a one to a flag register. If a new event and a clear land in the same cycle, the flag stays set.

All registers are reached over a simple single-cycle bus with byte address, write data, write strobe and combinational read data. Each group owns a 0x80-byte window. A write-protect input blocks writes to the watch registers. A blocked write leaves the register unchanged and produces a one-cycle error pulse.

Top module: `pinsec_mon`

## Requirements
- R1: After reset every watch register reads 0x00000000, every attribute register reads 0x00000000, every flag reads 0, `irq_o` is all zeros and `werr_o` is 0.
- R2: Group g occupies byte addresses g*0x80 to g*0x80+0x7F. Within a group the attribute register is at offset 0x6C, the watch register at 0x70, and the flag register at 0x74 (flag in bit 0, other bits read 0). Reads of any other offset, or of a group beyond the last one, return 0.
- R3: For a pin whose watch bit is 0, a 0-to-1 change of its attribute bit sets the group flag, and a 1-to-0 change does not.
- R4: For a pin whose watch bit is 1, a 1-to-0 change of its attribute bit sets the group flag, and a 0-to-1 change does not.
- R5: Detection compares the attribute register with its value one cycle earlier. For an attribute write captured at clock edge E, the flag and `irq_o` change at edge E+1.
- R6: Changing a watch register while the attribute stays constant never sets the flag, even when the attribute then differs from the watch bits.
- R7: The flag is sticky. It is cleared only by a write with bit 0 = 1 to the flag register, and a write with bit 0 = 0 leaves it unchanged.
- R8: When a detection event and a clearing write occur in the same cycle, the flag is left set.
- R9: While `wprot_i` is 1, a write to a watch register leaves it unchanged, and `werr_o` is 1 during the single cycle after that write. Attribute and flag writes are not affected by `wprot_i`.
- R10: Groups are independent. `irq_o[g]` is the flag of group g, and events, clears and writes in one group do not change another group's registers or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address: group index above bit 6, register offset in bits 6:0 |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, captured at the rising edge |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| wprot_i | input | 1 | Write protect for the watch registers |
| irq_o | output | NUM_GROUPS | Sticky detection flag per group |
| werr_o | output | 1 | One-cycle pulse after a blocked watch write |

## Verification
The bench targets direction selection. Each watch polarity is run against both a rise and a fall, and mixed patterns are used in which every change goes in the ignored direction. A design that reported any change, or swapped the polarities, would raise the flag on those patterns. The bench samples the flag exactly one cycle after the attribute write and again one cycle later, which catches a design that skips the previous-value register or adds an extra stage. It changes a watch register under a steady attribute, which exposes a design that compares levels instead of edges. It also overlaps a clear with an event, which catches a design where the clear wins. Finally, it writes the watch register under protection and checks the value read back and the width of the error pulse, which catches a design that leaks the write or holds the error high.

// File: rtl/pinsec_pkg.sv
package pinsec_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned OFF_W     = 7;
  localparam int unsigned GRP_SPAN  = 1 << OFF_W;

  localparam logic [OFF_W-1:0] OFF_ATTR  = 7'h6C;
  localparam logic [OFF_W-1:0] OFF_WATCH = 7'h70;
  localparam logic [OFF_W-1:0] OFF_FLAG  = 7'h74;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_ATTR  = 2'd1,
    SEL_WATCH = 2'd2,
    SEL_FLAG  = 2'd3
  } reg_sel_e;

  // Map a register offset inside a group window to a register.
  function automatic reg_sel_e decode_off(input logic [OFF_W-1:0] off);
    reg_sel_e s;
    case (off)
      OFF_ATTR:  s = SEL_ATTR;
      OFF_WATCH: s = SEL_WATCH;
      OFF_FLAG:  s = SEL_FLAG;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

  // A pin hits when its attribute bit toggled and now disagrees with the
  // expected value held in its watch bit.
  function automatic logic [WORD_W-1:0] watch_hits(input logic [WORD_W-1:0] prev,
                                                   input logic [WORD_W-1:0] cur,
                                                   input logic [WORD_W-1:0] watch);
    logic [WORD_W-1:0] toggled;
    logic [WORD_W-1:0] mismatch;
    toggled  = prev ^ cur;
    mismatch = cur ^ watch;
    return toggled & mismatch;
  endfunction

endpackage

// File: rtl/pinsec_decode.sv
module pinsec_decode
  import pinsec_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned GIDX_W     = 1,
  parameter int unsigned ADDR_W     = GIDX_W + OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [GIDX_W-1:0] grp_idx,
  output logic              grp_valid,
  output reg_sel_e          sel
);

  always_comb begin
    grp_idx   = addr[ADDR_W-1:OFF_W];
    grp_valid = (32'(grp_idx) < 32'(NUM_GROUPS));
    sel       = grp_valid ? decode_off(addr[OFF_W-1:0]) : SEL_NONE;
  end

endmodule

// File: rtl/pinsec_group.sv
module pinsec_group
  import pinsec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_attr,
  input  logic              wr_watch,
  input  logic              wr_flag,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wprot,
  output logic [WORD_W-1:0] watch_q,
  output logic [WORD_W-1:0] attr_q,
  output logic              flag_q,
  output logic              set_evt,
  output logic              clr_evt,
  output logic              blk_evt
);

  logic [WORD_W-1:0] attr_prev_q;
  logic [WORD_W-1:0] hits;
  logic              watch_ok;

  assign watch_ok = wr_watch && !wprot;
  assign blk_evt  = wr_watch && wprot;
  assign clr_evt  = wr_flag && wdata[0];
  assign hits     = watch_hits(attr_prev_q, attr_q, watch_q);
  assign set_evt  = |hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      watch_q <= '0;
    end else if (watch_ok) begin
      watch_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q      <= '0;
      attr_prev_q <= '0;
    end else begin
      attr_prev_q <= attr_q;
      if (wr_attr) begin
        attr_q <= wdata;
      end
    end
  end

  // Set has priority over clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_evt) begin
      flag_q <= 1'b1;
    end else if (clr_evt) begin
      flag_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pinsec_mon.sv
module pinsec_mon
  import pinsec_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 2,
  parameter int unsigned GIDX_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  parameter int unsigned ADDR_W     = GIDX_W + OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  input  logic                  bus_we,
  output logic [WORD_W-1:0]     bus_rdata,
  input  logic                  wprot_i,
  output logic [NUM_GROUPS-1:0] irq_o,
  output logic                  werr_o
);

  logic [GIDX_W-1:0] grp_idx;
  logic              grp_valid;
  reg_sel_e          sel;

  logic [NUM_GROUPS-1:0][WORD_W-1:0] watch_vec;
  logic [NUM_GROUPS-1:0][WORD_W-1:0] attr_vec;
  logic [NUM_GROUPS-1:0]             flag_vec;
  logic [NUM_GROUPS-1:0]             set_evt;
  logic [NUM_GROUPS-1:0]             clr_evt;
  logic [NUM_GROUPS-1:0]             blk_evt;
  logic [NUM_GROUPS-1:0]             grp_hit;

  pinsec_decode #(
    .NUM_GROUPS (NUM_GROUPS),
    .GIDX_W     (GIDX_W),
    .ADDR_W     (ADDR_W)
  ) dec_i (
    .addr      (bus_addr),
    .grp_idx   (grp_idx),
    .grp_valid (grp_valid),
    .sel       (sel)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_hit[g] = bus_we && grp_valid && (grp_idx == GIDX_W'(g));

    pinsec_group grp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_attr  (grp_hit[g] && (sel == SEL_ATTR)),
      .wr_watch (grp_hit[g] && (sel == SEL_WATCH)),
      .wr_flag  (grp_hit[g] && (sel == SEL_FLAG)),
      .wdata    (bus_wdata),
      .wprot    (wprot_i),
      .watch_q  (watch_vec[g]),
      .attr_q   (attr_vec[g]),
      .flag_q   (flag_vec[g]),
      .set_evt  (set_evt[g]),
      .clr_evt  (clr_evt[g]),
      .blk_evt  (blk_evt[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (grp_valid) begin
      case (sel)
        SEL_ATTR:  bus_rdata = attr_vec[grp_idx];
        SEL_WATCH: bus_rdata = watch_vec[grp_idx];
        SEL_FLAG:  bus_rdata = {{(WORD_W-1){1'b0}}, flag_vec[grp_idx]};
        default:   bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      werr_o <= 1'b0;
    end else begin
      werr_o <= |blk_evt;
    end
  end

  assign irq_o = flag_vec;

endmodule

// File: rtl/pinsec_mon_chk.sv
module pinsec_mon_chk
  import pinsec_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             wprot_i,
  input logic                             werr_o,
  input logic [NUM_GROUPS-1:0]            irq_o,
  input logic [NUM_GROUPS-1:0]            set_evt,
  input logic [NUM_GROUPS-1:0]            clr_evt,
  input logic [NUM_GROUPS-1:0]            blk_evt,
  input logic [NUM_GROUPS-1:0][WORD_W-1:0] watch_vec,
  input logic [NUM_GROUPS-1:0][WORD_W-1:0] attr_vec
);

  AST_ERR_FROM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    werr_o |-> ($past(|blk_evt) && $past(wprot_i))); // R9

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      blk_evt[g] |=> $stable(watch_vec[g])); // R9

    AST_EVENT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[g] |-> (attr_vec[g] != $past(attr_vec[g]))); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[g] && !clr_evt[g]) |=> irq_o[g]); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_evt[g] |=> irq_o[g]); // R8

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_evt[g] && !set_evt[g]) |=> !irq_o[g]); // R7

    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[g]) |-> $past(set_evt[g])); // R5
  end

endmodule

bind pinsec_mon pinsec_mon_chk #(.NUM_GROUPS(NUM_GROUPS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .wprot_i   (wprot_i),
  .werr_o    (werr_o),
  .irq_o     (irq_o),
  .set_evt   (set_evt),
  .clr_evt   (clr_evt),
  .blk_evt   (blk_evt),
  .watch_vec (watch_vec),
  .attr_vec  (attr_vec)
);

// File: tb/pinsec_mon_tb_top.sv
`timescale 1ns/1ps
module pinsec_mon_tb_top;

  localparam int unsigned NG   = 2;
  localparam int unsigned AW   = 8;
  localparam logic [6:0] O_ATTR  = 7'h6C;
  localparam logic [6:0] O_WATCH = 7'h70;
  localparam logic [6:0] O_FLAG  = 7'h74;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_rdata;
  logic          wprot_i = 1'b0;
  logic [NG-1:0] irq_o;
  logic          werr_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pinsec_mon #(.NUM_GROUPS(NG)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .wprot_i   (wprot_i),
    .irq_o     (irq_o),
    .werr_o    (werr_o)
  );

  typedef struct packed {
    logic        grp;
    logic [31:0] watch;
    logic [31:0] a0;
    logic [31:0] a1;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 1'b1, 4'd3},  // R3 rise seen
    '{1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 4'd3},  // R3 fall ignored
    '{1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1, 4'd4},  // R4 fall seen
    '{1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0000, 1'b0, 4'd4},  // R4 rise ignored
    '{1'b1, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0001_FFFF, 1'b1, 4'd3},  // R3 group 1
    '{1'b1, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_FFFE, 1'b1, 4'd4},  // R4 group 1
    '{1'b1, 32'h0000_FFFF, 32'hFFFF_0000, 32'h0000_FFFF, 1'b0, 4'd4},  // R4 mixed, all ignored
    '{1'b1, 32'h5555_5555, 32'h5555_5555, 32'h5555_5555, 1'b0, 4'd10}  // R10 no change
  };

  function automatic logic [AW-1:0] adr(input int g, input logic [6:0] off);
    return AW'(g * 128) | AW'(off);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the capture edge.
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(adr(0, O_FLAG), 32'h1);
    wr(adr(1, O_FLAG), 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check({31'b0, werr_o}, 32'h0, "R1 werr");
    check({30'b0, irq_o}, 32'h0, "R1 irq");
    for (int g = 0; g < 2; g++) begin
      rd(adr(g, O_WATCH), d); check(d, 32'h0, "R1 watch");
      rd(adr(g, O_ATTR), d);  check(d, 32'h0, "R1 attr");
      rd(adr(g, O_FLAG), d);  check(d, 32'h0, "R1 flag");
    end
    idle(1);

    // R2 map: unmapped offset, per-group readback
    wr(adr(0, O_WATCH), 32'hA5A5_0F0F);
    wr(adr(1, O_WATCH), 32'h1234_5678);
    rd(adr(0, O_WATCH), d); check(d, 32'hA5A5_0F0F, "R2 watch g0");
    rd(adr(1, O_WATCH), d); check(d, 32'h1234_5678, "R2 watch g1 R10");
    rd(adr(0, 7'h00), d);   check(d, 32'h0, "R2 unmapped");
    rd(adr(1, 7'h7C), d);   check(d, 32'h0, "R2 unmapped end");
    idle(1);

    // Table walk: R3 R4 R10
    for (int i = 0; i < 8; i++) begin
      int g;
      g = int'(VECS[i].grp);
      wr(adr(g, O_WATCH), VECS[i].watch);
      wr(adr(g, O_ATTR), VECS[i].a0);
      idle(2);
      clear_all();
      check({30'b0, irq_o}, 32'h0, "R7 cleared before vector");
      wr(adr(g, O_ATTR), VECS[i].a1);
      idle(1);
      if (VECS[i].req == 4'd3)      check({30'b0, irq_o}, 32'(VECS[i].exp) << g, "R3 vector");
      else if (VECS[i].req == 4'd4) check({30'b0, irq_o}, 32'(VECS[i].exp) << g, "R4 vector");
      else                          check({30'b0, irq_o}, 32'(VECS[i].exp) << g, "R10 vector");
    end

    // R5 timing and R7 stickiness
    wr(adr(0, O_WATCH), 32'h0);
    wr(adr(0, O_ATTR), 32'h0);
    idle(2);
    clear_all();
    wr(adr(0, O_ATTR), 32'h0000_0100);
    check({31'b0, irq_o[0]}, 32'h0, "R5 not yet");
    idle(1);
    check({31'b0, irq_o[0]}, 32'h1, "R5 one cycle later");
    idle(5);
    check({31'b0, irq_o[0]}, 32'h1, "R7 sticky");
    wr(adr(0, O_FLAG), 32'h0);
    rd(adr(0, O_FLAG), d); check(d, 32'h1, "R7 write zero ignored");
    wr(adr(0, O_FLAG), 32'h1);
    rd(adr(0, O_FLAG), d); check(d, 32'h0, "R7 clear");

    // R6 watch change alone
    wr(adr(0, O_WATCH), 32'hFFFF_0000);
    idle(3);
    check({30'b0, irq_o}, 32'h0, "R6 watch change only");

    // R8 set wins over clear
    wr(adr(0, O_WATCH), 32'h0);
    idle(2);
    wr(adr(0, O_ATTR), 32'h0000_0300);
    wr(adr(0, O_FLAG), 32'h1);
    check({31'b0, irq_o[0]}, 32'h1, "R8 set wins");
    wr(adr(0, O_FLAG), 32'h1);
    check({31'b0, irq_o[0]}, 32'h0, "R8 later clear");

    // R9 write protection
    wprot_i = 1'b1;
    wr(adr(1, O_WATCH), 32'hDEAD_BEEF);
    check({31'b0, werr_o}, 32'h1, "R9 error pulse");
    rd(adr(1, O_WATCH), d); check(d, 32'h5555_5555, "R9 watch held");
    idle(1);
    check({31'b0, werr_o}, 32'h0, "R9 pulse one cycle");
    wr(adr(1, O_ATTR), 32'h0F0F_0F0F);
    rd(adr(1, O_ATTR), d); check(d, 32'h0F0F_0F0F, "R9 attr not protected");
    check({31'b0, werr_o}, 32'h0, "R9 no error on attr");
    wprot_i = 1'b0;
    wr(adr(1, O_WATCH), 32'hCAFE_0001);
    rd(adr(1, O_WATCH), d); check(d, 32'hCAFE_0001, "R9 unprotected write");
    check({31'b0, werr_o}, 32'h0, "R9 no error unprotected");
    rd(adr(0, O_WATCH), d); check(d, 32'h0, "R10 group 0 untouched");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule